// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in main memory. A requester hands over an address and says whether the access is a load or a store. The walker then makes word reads on a plain memory request/response port. The first read fetches the top-level directory entry and the second fetches the leaf page entry. The walker then returns either a physical address or a fault code.

The root of the top-level table comes from a base register that software rewrites whenever the running process changes. The walker serves one request at a time. A base-register update that arrives while a walk is running leaves that walk alone and applies from the next accepted request onward.

Each table entry carries a frame number in bits 31:12. Bit 0 is the present flag, bit 1 allows loads and bit 2 allows stores. The 12-bit page offset passes straight through to the physical address.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, reqReady is 1, rspValid is 0 and memReqValid is 0.
- R2: The first memory read of a walk goes to the base value plus 4 times vaddr[31:22]. While memReqValid is high and memReqReady is low, memReqValid stays high and memReqAddr does not change.
- R3: The second read goes to the first entry's bits 31:12 shifted left by 12, plus 4 times vaddr[21:12].
- R4: A successful walk makes exactly two reads. It then raises rspValid with rspFault = 0 and rspPaddr = {leaf entry bits 31:12, vaddr[11:0]}. rspFault only ever takes the values 0, 1 or 2.
- R5: An entry whose bit 0 is clear, at either level, ends the walk with rspFault = 1 and rspPaddr = 0. A clear bit 0 in the first entry ends the walk after a single read. Bit 0 is checked before any permission bit.
- R6: A present leaf entry ends the walk with rspFault = 2 and rspPaddr = 0 in either of two cases: a load finds bit 1 clear, or a store finds bit 2 clear.
- R7: reqReady is high only when no walk is in progress, so a request held during a walk is not taken. rspValid lasts exactly one cycle, and reqReady is high again in the cycle after it.
- R8: A write to the base register applies to requests accepted in later cycles. A walk already in progress keeps its old root. A request accepted in the same cycle as the write also uses the old root.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request taken on this cycle if valid |
| reqVaddr | input | 32 | Virtual address to translate |
| reqStore | input | 1 | 1 for a store access, 0 for a load |
| rspValid | output | 1 | One-cycle result strobe |
| rspPaddr | output | 32 | Physical address, 0 on a fault |
| rspFault | output | 2 | 0 none, 1 not present, 2 permission |
| baseWe | input | 1 | Base register write strobe |
| baseData | input | 32 | New table root address |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Word address of the read |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 32 | Table entry read back |

## Verification
Random addresses are drawn over mapped and unmapped top-level slots and leaf slots, with random permission bits and random load/store choice. These draws separate the three outcomes and confirm both read addresses on every walk. Directed walks isolate the permission cases: a load against a store-only page, a store against a read-only page, and a non-present entry that still has permission bits set, which shows that the present flag is checked first. The highest top and leaf indices with offset 0xFFF exercise the carry-free address arithmetic at its edge. Base-register writes during a walk and in the acceptance cycle tell old-root from new-root behaviour apart, and random memory stalls exercise the hold rule on the read port.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // entry flag positions (fixed by the table format software writes)
  localparam int PRESENT_BIT = 0;
  localparam int LOAD_BIT    = 1;
  localparam int STORE_BIT   = 2;

  typedef enum logic [2:0] {
    IDLE    = 3'd0,
    READ_L1 = 3'd1,
    WAIT_L1 = 3'd2,
    READ_L2 = 3'd3,
    WAIT_L2 = 3'd4,
    DONE    = 3'd5,
    FAULT   = 3'd6
  } walkState_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PERM   = 2'd2
  } fault_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadL2;
    logic loadLeaf;
    logic setAbsent;
    logic setPerm;
  } walkCtl_t;

  // decoded entry status from datapath to control
  typedef struct packed {
    logic entryPresent;
    logic permOk;
  } entryStat_t;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       memReqValid,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  entryStat_t stat,
  output walkCtl_t   ctl,
  output logic       rspValid
);

  walkState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          nextState   = READ_L1;
        end
      end
      READ_L1: if (memReqReady) nextState = WAIT_L1;
      WAIT_L1: begin
        if (memRspValid) begin
          if (!stat.entryPresent) begin
            ctl.setAbsent = 1'b1;
            nextState     = FAULT;
          end else begin
            ctl.loadL2 = 1'b1;
            nextState  = READ_L2;
          end
        end
      end
      READ_L2: if (memReqReady) nextState = WAIT_L2;
      WAIT_L2: begin
        if (memRspValid) begin
          if (!stat.entryPresent) begin
            ctl.setAbsent = 1'b1;
            nextState     = FAULT;
          end else if (!stat.permOk) begin
            ctl.setPerm = 1'b1;
            nextState   = FAULT;
          end else begin
            ctl.loadLeaf = 1'b1;
            nextState    = DONE;
          end
        end
      end
      DONE:    nextState = IDLE;
      FAULT:   nextState = IDLE;
      default: nextState = IDLE;
    endcase
  end

  assign reqReady    = (state == IDLE);
  assign memReqValid = (state == READ_L1) || (state == READ_L2);
  assign rspValid    = (state == DONE) || (state == FAULT);

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqStore,
  input  logic              baseWe,
  input  logic [ADDR_W-1:0] baseData,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [1:0]        rspFault,
  output entryStat_t        stat
);

  localparam int LOW_W = ADDR_W - IDX_W;   // leaf index plus offset
  localparam int PFN_W = ADDR_W - OFF_W;
  localparam int PAD_W = ADDR_W - IDX_W - 2;

  logic [ADDR_W-1:0] baseReg;
  logic [LOW_W-1:0]  curLow;
  logic              curStore;
  logic [ADDR_W-1:0] walkAddr;
  logic [ADDR_W-1:0] physAddr;
  fault_t            faultCode;

  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  leafIdx;
  logic [PFN_W-1:0]  entryPfn;
  logic [ADDR_W-1:0] l1Addr;
  logic [ADDR_W-1:0] l2Addr;
  logic [OFF_W-1:PFN_W > 0 ? STORE_BIT+1 : 0] unusedEntryBits;

  assign topIdx          = reqVaddr[ADDR_W-1 -: IDX_W];
  assign leafIdx         = curLow[LOW_W-1 -: IDX_W];
  assign entryPfn        = memRspData[ADDR_W-1:OFF_W];
  assign unusedEntryBits = memRspData[OFF_W-1:STORE_BIT+1];

  assign l1Addr = baseReg + {{PAD_W{1'b0}}, topIdx, 2'b00};
  assign l2Addr = {entryPfn, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, leafIdx, 2'b00};

  // root register: software updates apply when the next request is captured
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       baseReg <= '0;
    else if (baseWe) baseReg <= baseData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLow    <= '0;
      curStore  <= 1'b0;
      walkAddr  <= '0;
      physAddr  <= '0;
      faultCode <= FLT_NONE;
    end else begin
      if (ctl.loadReq) begin
        curLow    <= reqVaddr[LOW_W-1:0];
        curStore  <= reqStore;
        walkAddr  <= l1Addr;
        physAddr  <= '0;
        faultCode <= FLT_NONE;
      end
      if (ctl.loadL2)    walkAddr  <= l2Addr;
      if (ctl.loadLeaf)  physAddr  <= {entryPfn, curLow[OFF_W-1:0]};
      if (ctl.setAbsent) faultCode <= FLT_ABSENT;
      if (ctl.setPerm)   faultCode <= FLT_PERM;
    end
  end

  assign stat.entryPresent = memRspData[PRESENT_BIT];
  assign stat.permOk       = curStore ? memRspData[STORE_BIT] : memRspData[LOAD_BIT];

  assign memReqAddr = walkAddr;
  assign rspPaddr   = physAddr;
  assign rspFault   = faultCode;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqStore,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [1:0]        rspFault,
  input  logic              baseWe,
  input  logic [ADDR_W-1:0] baseData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData
);

  walkCtl_t   ctl;
  entryStat_t stat;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .stat        (stat),
    .ctl         (ctl),
    .rspValid    (rspValid)
  );

  ptw_datapath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqVaddr   (reqVaddr),
    .reqStore   (reqStore),
    .baseWe     (baseWe),
    .baseData   (baseData),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .rspPaddr   (rspPaddr),
    .rspFault   (rspFault),
    .stat       (stat)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic [1:0]        rspFault,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr
);

  // R7
  idle_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReqValid && !rspValid));

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R5
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> (rspPaddr == '0));

  // R4
  fault_code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspFault != 2'd3));

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .rspValid    (rspValid),
  .rspPaddr    (rspPaddr),
  .rspFault    (rspFault),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/100ps
module pt_walker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqStore = 1'b0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic [1:0]  rspFault;
  logic        baseWe = 1'b0;
  logic [31:0] baseData = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mem [int unsigned];
  logic [31:0] rdLog [int];
  int          totalReads = 0;
  logic [31:0] modelBase = '0;

  always #2.5 clk = ~clk;

  pt_walker u_dut (.*);

  function automatic logic [31:0] rdMem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // expected walk outcome from the requirements
  task automatic model(input logic [31:0] base, input logic [31:0] va, input bit st,
                       output logic [1:0] flt, output logic [31:0] pa, output int nRd,
                       output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] e1, e2;
    a1 = base + {20'h0, va[31:22], 2'b00};
    e1 = rdMem(a1);
    a2 = '0;
    pa = '0;
    if (!e1[0]) begin
      flt = 2'd1; nRd = 1;
    end else begin
      a2 = {e1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
      e2 = rdMem(a2);
      nRd = 2;
      if (!e2[0])                    flt = 2'd1;
      else if (st ? !e2[2] : !e2[1]) flt = 2'd2;
      else begin
        flt = 2'd0; pa = {e2[31:12], va[11:0]};
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random stall before accepting, random latency to data
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (rstN && memReqValid) begin
        logic [31:0] a;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        memReqReady = 1'b1;
        a = memReqAddr;
        rdLog[totalReads] = a;
        totalReads++;
        @(negedge clk);
        memReqReady = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        memRspData  = rdMem(a);
        memRspValid = 1'b1;
      end
    end
  end

  // mode 0: plain, 1: base write during walk, 2: base write in acceptance cycle
  task automatic runWalk(input logic [31:0] va, input bit st, input int mode,
                         input logic [31:0] newBase, input string tag);
    logic [1:0] eFlt; logic [31:0] ePa, a1, a2; int nRd, startRd, n;
    bit got;
    model(modelBase, va, st, eFlt, ePa, nRd, a1, a2);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    startRd  = totalReads;
    reqVaddr = va;
    reqStore = st;
    reqValid = 1'b1;
    if (mode == 2) begin baseWe = 1'b1; baseData = newBase; end
    @(negedge clk);
    reqValid = 1'b0;
    baseWe   = 1'b0;
    if (mode == 1) begin baseWe = 1'b1; baseData = newBase; end
    check(reqReady == 1'b0, {"R7 busy after accept ", tag}, 32'(reqReady), 32'h0);
    got = 1'b0;
    n = 0;
    while (!got && n < 60) begin
      @(negedge clk);
      baseWe = 1'b0;
      if (rspValid) got = 1'b1;
      else if (reqReady) begin
        check(1'b0, {"R7 ready during walk ", tag}, 32'(reqReady), 32'h0);
      end
      n++;
    end
    check(got, {"R7 response seen ", tag}, 32'(got), 32'h1);
    if (got) begin
      check(rspFault == eFlt, {eFlt == 0 ? "R4 " : (eFlt == 1 ? "R5 " : "R6 "), "fault ", tag},
            32'(rspFault), 32'(eFlt));
      check(rspPaddr == ePa, {eFlt == 0 ? "R4 " : "R5 R6 ", "paddr ", tag}, rspPaddr, ePa);
      check(totalReads - startRd == nRd, {"R5 read count ", tag}, 32'(totalReads - startRd), 32'(nRd));
      check(rdLog.exists(startRd) && rdLog[startRd] == a1, {mode != 0 ? "R8 " : "R2 ", "first addr ", tag},
            rdLog.exists(startRd) ? rdLog[startRd] : 32'hx, a1);
      if (nRd == 2)
        check(rdLog.exists(startRd + 1) && rdLog[startRd + 1] == a2, {"R3 second addr ", tag},
              rdLog.exists(startRd + 1) ? rdLog[startRd + 1] : 32'hx, a2);
      @(negedge clk);
      check(!rspValid && reqReady, {"R7 pulse end ", tag}, {30'h0, rspValid, reqReady}, 32'h1);
    end
    if (mode != 0) modelBase = newBase;
  endtask

  task automatic setBase(input logic [31:0] b);
    @(negedge clk);
    baseWe = 1'b1; baseData = b;
    @(negedge clk);
    baseWe = 1'b0;
    modelBase = b;
  endtask

  task automatic buildTables(input logic [31:0] base, input logic [19:0] frame0);
    for (int i = 0; i < 8; i++) begin
      mem[base + 32'(i * 4)] = {frame0 + 20'(i), 12'h001};
      for (int j = 0; j < 18; j++) begin
        logic [31:0] e;
        e = {20'($urandom), 9'h0, 3'($urandom)};
        if ($urandom_range(0, 3) != 0) e[0] = 1'b1;
        mem[{frame0 + 20'(i), 12'h0} + 32'(j * 4)] = e;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    buildTables(32'h0010_0000, 20'h00200);
    buildTables(32'h0030_0000, 20'h00400);
    // directed leaf entries under top slot 0 of the first table
    mem[32'h0020_0000] = 32'hABCDE_003;   // present, loads only
    mem[32'h0020_0004] = 32'h12345_005;   // present, stores only
    mem[32'h0020_0008] = 32'h77777_006;   // permissions set, not present
    // top slot 1023 and leaf slot 1023
    mem[32'h0010_0FFC] = 32'h00500_001;
    mem[32'h0050_0FFC] = 32'hFFFFF_007;

    repeat (4) @(negedge clk);
    check(reqReady && !rspValid && !memReqValid, "R1 in reset", {29'h0, reqReady, rspValid, memReqValid}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspValid && !memReqValid, "R1 after reset", {29'h0, reqReady, rspValid, memReqValid}, 32'h4);

    setBase(32'h0010_0000);
    runWalk(32'h0000_0123, 1'b0, 0, 0, "load on read-only page");
    runWalk(32'h0000_0123, 1'b1, 0, 0, "store on read-only page");
    runWalk(32'h0000_1456, 1'b1, 0, 0, "store on store-only page");
    runWalk(32'h0000_1456, 1'b0, 0, 0, "load on store-only page");
    runWalk(32'h0000_2789, 1'b0, 0, 0, "absent leaf with perms");
    runWalk(32'h0240_0000, 1'b0, 0, 0, "absent top slot");
    runWalk(32'hFFFF_FFFF, 1'b1, 0, 0, "max indices and offset");

    runWalk(32'h0040_5ABC, 1'b0, 1, 32'h0030_0000, "base write mid walk");
    runWalk(32'h0040_5ABC, 1'b0, 0, 0, "new base applied");
    runWalk(32'h0000_3111, 1'b1, 2, 32'h0010_0000, "base write at accept");
    runWalk(32'h0000_3111, 1'b1, 0, 0, "base after accept write");

    for (int k = 0; k < 60; k++) begin
      logic [31:0] va;
      va = {10'($urandom_range(0, 9)), 10'($urandom_range(0, 17)), 12'($urandom)};
      if (k == 30) setBase(32'h0030_0000);
      runWalk(va, 1'($urandom), 0, 0, "random");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule